// File: doc/BRIEF.md
# Filtered Tamper Pin Detector

This block watches one external anti-tamper pin in the slow kernel-clock domain and raises a single-cycle event pulse when that pin signals an intrusion. The pin first passes through a two-flop synchroniser. The block then works in one of two ways. In edge mode it fires as soon as the pin moves to its active level. In level mode it samples the pin at a programmable slow rate and fires once a run of consecutive samples has matched the active level.

In level mode, every sample is preceded by a short window in which the block asks the pad to turn on its pull-up. This precharges any capacitance on the line, so that an open or cut wire reads at a defined level. The flag storage that sits downstream feeds back a blocking input. While a tamper is still pending there, this input stops new detections. Configuration comes in as static inputs: enable, polarity, filter code, sampling-rate code, precharge code and pull-up disable.

Top module: `tamper_pin_detect`

## Requirements
- R1: During and straight after reset, `event_o` and `pullup_o` are both low.
- R2: With filter code 0 (edge mode), a move of `pin_i` to the active level gives a pulse on `event_o` exactly one cycle wide. The pulse is high in the third cycle after the edge at which the new pin level is first sampled (two synchroniser flops, then a registered output).
- R3: `pol_i` = 0 makes high (rising) the active level. `pol_i` = 1 makes low (falling) the active level. A move to the inactive level never fires.
- R4: In edge mode, the inactive state is assumed while the block is disabled. Enabling the block while the synchronised pin is already active therefore produces an event one cycle after enable.
- R5: Filter codes 1, 2 and 3 select level mode and need 2, 4 and 8 consecutive active samples. The event comes in the cycle after the sample that completes the run.
- R6: In level mode, one sample is taken every 2^(15−freq_i) kernel cycles (code 0 → 32768, code 7 → 256). The count starts from 0 at enable, so sample k falls at clock edge k·period.
- R7: With `pu_dis_i` = 0 in level mode, `pullup_o` is high for exactly 2^prch_i cycles (1, 2, 4 or 8). These are the last cycles of each period, ending with the sample cycle.
- R8: `pullup_o` stays low when `pu_dis_i` = 1 or when edge mode is selected.
- R9: A sample at the inactive level clears the run of matching samples. So does disabling the block.
- R10: After a level-mode event, no further event fires until at least one sample has seen the inactive level and a fresh full run has followed.
- R11: While `block_i` is high, no event fires. In level mode a completed run stays pending and fires at the first active sample after `block_i` falls.
- R12: While `en_i` is low, neither `event_o` nor `pullup_o` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw tamper pin, asynchronous |
| en_i | input | 1 | Detection enable |
| pol_i | input | 1 | Active level select: 0 high/rising, 1 low/falling |
| flt_i | input | 2 | Filter code: 0 edge, 1/2/3 run of 2/4/8 samples |
| freq_i | input | 3 | Sampling-rate code, period 2^(15−code) cycles |
| prch_i | input | 2 | Precharge length code, 2^code cycles |
| pu_dis_i | input | 1 | Suppresses the precharge pull-up |
| block_i | input | 1 | Downstream flag pending, blocks new events |
| event_o | output | 1 | One-cycle tamper event |
| pullup_o | output | 1 | Pad pull-up enable for precharge |

## Verification
Edge-mode events are due three clock edges after the pin changes. The bench drives the pin at a falling edge and samples `event_o` after exactly two edges (expects low), three edges (expects high) and four edges (expects low). Level-mode events are due at edge N·period after enable, counted from a counter cleared at enable. The bench checks that no event appears at any earlier falling-edge sample in that window and that the event is present right after edge N·period. Precharge windows, re-arming, run resets and blocking are checked by counting `event_o` and `pullup_o` high cycles over windows whose length is a whole number of periods. Each window is sized so that the synchroniser's two-cycle lag cannot move a sample across its boundary.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  // Filter code meaning; only the zero code changes the detection style.
  typedef enum logic [1:0] {
    FLT_EDGE = 2'd0,
    FLT_RUN2 = 2'd1,
    FLT_RUN4 = 2'd2,
    FLT_RUN8 = 2'd3
  } flt_code_e;

endpackage

// File: rtl/tpd_sync.sv
module tpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/tpd_prescaler.sv
module tpd_prescaler #(
  parameter int DIV_LOG = 15,
  parameter int FREQ_W  = 3,
  parameter int PRCH_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [PRCH_W-1:0] prch_i,
  input  logic              pu_dis_i,
  output logic              sample_o,
  output logic              pullup_o
);

  localparam int CW = DIV_LOG + 2;

  logic [DIV_LOG-1:0] tick_q, tick_d;
  logic [CW-1:0]      period, pre_len, tick_ext;
  logic               wrap;

  always_comb begin
    period   = CW'(1) << (DIV_LOG - int'(freq_i));
    pre_len  = CW'(1) << prch_i;
    tick_ext = CW'(tick_q);
    wrap     = (tick_ext >= (period - CW'(1)));
    if (!run_i)    tick_d = '0;
    else if (wrap) tick_d = '0;
    else           tick_d = tick_q + DIV_LOG'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

  assign sample_o = run_i & wrap;
  assign pullup_o = run_i & ~pu_dis_i & ((tick_ext + pre_len) >= period);

endmodule

// File: rtl/tpd_filter.sv
module tpd_filter #(
  parameter int RUN_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       edge_mode_i,
  input  logic       act_i,
  input  logic       sample_i,
  input  logic       block_i,
  input  logic [1:0] flt_i,
  output logic       event_o
);

  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic             prev_q, prev_d;
  logic [RUN_W-1:0] run_q, run_d, run_inc, target;
  logic             armed_q, armed_d;
  logic             event_q, event_d;
  logic             edge_fire, lvl_fire;

  always_comb begin
    target    = RUN_W'(1) << flt_i;
    run_inc   = (run_q == RUN_MAX) ? run_q : run_q + RUN_W'(1);
    prev_d    = en_i ? act_i : 1'b0;
    edge_fire = en_i & edge_mode_i & act_i & ~prev_q;
    lvl_fire  = 1'b0;
    run_d     = run_q;
    armed_d   = armed_q;
    if (!en_i || edge_mode_i) begin
      run_d   = '0;
      armed_d = 1'b1;
    end else if (sample_i) begin
      if (act_i) begin
        run_d = run_inc;
        if (armed_q && (run_inc >= target) && !block_i) begin
          lvl_fire = 1'b1;
          armed_d  = 1'b0;
        end
      end else begin
        run_d   = '0;
        armed_d = 1'b1;
      end
    end
    event_d = ~block_i & (edge_fire | lvl_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      run_q   <= '0;
      armed_q <= 1'b1;
      event_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      run_q   <= run_d;
      armed_q <= armed_d;
      event_q <= event_d;
    end
  end

  assign event_o = event_q;

endmodule

// File: rtl/tamper_pin_detect.sv
module tamper_pin_detect #(
  parameter int DIV_LOG     = 15,
  parameter int FREQ_W      = 3,
  parameter int PRCH_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RUN_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              en_i,
  input  logic              pol_i,
  input  logic [1:0]        flt_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [PRCH_W-1:0] prch_i,
  input  logic              pu_dis_i,
  input  logic              block_i,
  output logic              event_o,
  output logic              pullup_o
);

  import tpd_pkg::*;

  logic pin_s, act, edge_mode, lvl_run, sample;

  tpd_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  assign act       = pin_s ^ pol_i;
  assign edge_mode = (flt_code_e'(flt_i) == FLT_EDGE);
  assign lvl_run   = en_i & ~edge_mode;

  tpd_prescaler #(.DIV_LOG(DIV_LOG), .FREQ_W(FREQ_W), .PRCH_W(PRCH_W)) i_presc (
    .clk(clk), .rst_n(rst_n), .run_i(lvl_run), .freq_i(freq_i),
    .prch_i(prch_i), .pu_dis_i(pu_dis_i), .sample_o(sample), .pullup_o(pullup_o)
  );

  tpd_filter #(.RUN_W(RUN_W)) i_filt (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .edge_mode_i(edge_mode),
    .act_i(act), .sample_i(sample), .block_i(block_i), .flt_i(flt_i),
    .event_o(event_o)
  );

endmodule

// File: rtl/tpd_chk.sv
module tpd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       block_i,
  input logic       pu_dis_i,
  input logic [1:0] flt_i,
  input logic       event_o,
  input logic       pullup_o
);

  // R12
  pullup_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_o |-> en_i);

  // R8
  pullup_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pullup_o |-> (!pu_dis_i && flt_i != 2'd0));

  // R2
  event_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> !event_o);

  // R11
  event_unblocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(en_i && !block_i));

  // R7
  level_event_precharged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o && flt_i != 2'd0 && $past(flt_i) != 2'd0 && !pu_dis_i && $past(!pu_dis_i))
      |-> $past(pullup_o));

endmodule

bind tamper_pin_detect tpd_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .block_i(block_i),
  .pu_dis_i(pu_dis_i), .flt_i(flt_i), .event_o(event_o), .pullup_o(pullup_o)
);

// File: tb/test_tamper_pin_detect.sv
`timescale 1ns/1ps
module test_tamper_pin_detect;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin, en, pol, pu_dis, block;
  logic [1:0] flt, prch;
  logic [2:0] freq;
  logic       ev, pu;

  int n_checks = 0;
  int n_fail   = 0;
  int ev_cnt, pu_cnt;

  always #10 clk = ~clk;

  tamper_pin_detect i_tamper_pin_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .en_i(en), .pol_i(pol),
    .flt_i(flt), .freq_i(freq), .prch_i(prch), .pu_dis_i(pu_dis),
    .block_i(block), .event_o(ev), .pullup_o(pu)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic adv(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tally(input int k);
    ev_cnt = 0;
    pu_cnt = 0;
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
      ev_cnt += int'(ev);
      pu_cnt += int'(pu);
    end
  endtask

  task automatic idle();
    en = 0; pol = 0; pin = 0; flt = 0; freq = 7; prch = 0;
    pu_dis = 0; block = 0;
    adv(4);
  endtask

  task automatic t_reset();
    check("R1 event", int'(ev), 0);
    check("R1 pullup", int'(pu), 0);
  endtask

  task automatic t_edge_rise();
    idle();
    en = 1; adv(4);
    pin = 1;
    adv(2); check("R2 early", int'(ev), 0);
    adv(1); check("R2 pulse", int'(ev), 1);
    adv(1); check("R2 width", int'(ev), 0);
    tally(8); check("R8 edge pullup", pu_cnt, 0);
  endtask

  task automatic t_edge_fall();
    idle();
    pol = 1; pin = 1; adv(4);
    en = 1; tally(6); check("R3 inactive high", ev_cnt, 0);
    pin = 0;
    adv(2); check("R3 early", int'(ev), 0);
    adv(1); check("R3 falling pulse", int'(ev), 1);
    pin = 1; tally(10); check("R3 rising ignored", ev_cnt, 0);
  endtask

  task automatic t_enable_active();
    idle();
    pin = 1; adv(4);
    en = 1;
    adv(1); check("R4 enable fire", int'(ev), 1);
    adv(1); check("R4 width", int'(ev), 0);
  endtask

  task automatic t_block_edge();
    idle();
    en = 1; adv(4);
    block = 1; pin = 1;
    tally(10); check("R11 edge blocked", ev_cnt, 0);
    block = 0;
  endtask

  task automatic t_disabled();
    idle();
    flt = 1;
    for (int i = 0; i < 4; i++) begin
      pin = ~pin;
      tally(300);
      check("R12 no event", ev_cnt, 0);
      check("R12 no pullup", pu_cnt, 0);
    end
  endtask

  task automatic t_level(input int f, input int fr, input int pc);
    int per, n, l;
    per = 1 << (15 - fr); n = 1 << f; l = 1 << pc;
    idle();
    pin = 1; adv(4);
    flt = 2'(f); freq = 3'(fr); prch = 2'(pc); en = 1;
    tally(per);
    check("R7 precharge length", pu_cnt, l);
    check("R5 no early", ev_cnt, 0);
    tally(n * per - per - 1);
    check("R6 no event before run", ev_cnt, 0);
    adv(1); check("R5 R6 event on time", int'(ev), 1);
    tally(3 * per); check("R10 no refire", ev_cnt, 0);
    pin = 0; tally(2 * per); check("R10 inactive", ev_cnt, 0);
    pin = 1; tally((n + 1) * per); check("R10 rearmed", ev_cnt, 1);
    en = 0;
  endtask

  task automatic t_pudis();
    idle();
    pin = 1; flt = 1; pu_dis = 1; prch = 3; en = 1;
    tally(512);
    check("R8 pull-up disabled", pu_cnt, 0);
    check("R5 still detects", ev_cnt, 1);
  endtask

  task automatic t_mismatch();
    idle();
    pin = 1; adv(4);
    flt = 2; en = 1;
    adv(3 * 256 + 10);
    pin = 0; tally(256); check("R9 low sample", ev_cnt, 0);
    pin = 1; tally(4 * 256 - 11); check("R9 run cleared", ev_cnt, 0);
    adv(1); check("R9 fresh run", int'(ev), 1);
  endtask

  task automatic t_disable_reset();
    idle();
    pin = 1; adv(4);
    flt = 1; en = 1;
    adv(256 + 5);
    en = 0; adv(1);
    en = 1;
    tally(2 * 256 - 1); check("R9 disable clears run", ev_cnt, 0);
    adv(1); check("R9 after reenable", int'(ev), 1);
  endtask

  task automatic t_block_level();
    idle();
    pin = 1; adv(4);
    flt = 1; block = 1; en = 1;
    tally(3 * 256); check("R11 level blocked", ev_cnt, 0);
    block = 0;
    tally(256); check("R11 pending fires", ev_cnt, 1);
  endtask

  initial begin
    rst_n = 0;
    en = 0; pol = 0; pin = 0; flt = 0; freq = 7; prch = 0; pu_dis = 0; block = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    adv(1);
    t_reset();
    t_edge_rise();
    t_edge_fall();
    t_enable_active();
    t_block_edge();
    t_disabled();
    t_level(1, 6, 0);
    t_level(2, 7, 3);
    t_level(3, 7, 1);
    t_pudis();
    t_mismatch();
    t_disable_reset();
    t_block_level();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule